// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page translations for a processor's memory pipeline. Each slot holds one mapping: a virtual page number used as its tag, the address space number of the process that owns it, a physical page number, per-privilege-mode read and write enables, two fault-on-access bits and a global bit. A global mapping is shared by every address space. A lookup presents a virtual page number together with the current address space number. In the same cycle it returns a hit flag, the matching slot and the stored fields.

New mappings are written into the slot chosen by a single round-robin replacement pointer. Whatever that slot held before is overwritten. Three invalidation commands are available. The first wipes the whole buffer. The second drops every mapping that is not global, which is what a context switch needs. The third drops only the mappings that a given page and address space number would hit. An index-read port exposes the slot under the replacement pointer and can step the pointer without inserting anything. Walking page tables, raising faults and enforcing permissions are left to the surrounding logic.

Top module: `asn_tagged_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global bit is set or whose stored number equals `lk_asn`; on a miss, `lk_slot` and every returned field read zero.
- R2: When several slots hit, the lowest-numbered one is returned in `lk_slot` together with its fields.
- R3: With `ins_en` high, the slot at the replacement pointer takes the inserted fields on the next clock edge and becomes valid with its tag set to `ins_vpn`, replacing any previous contents; lookups see it from the following cycle.
- R4: The replacement pointer `rp_slot` advances by one on each insert and wraps from slot ENTRIES-1 back to slot 0.
- R5: `flush_op` = 1 (flush all) clears every slot, valid bits included, and returns `rp_slot` to 0.
- R6: `flush_op` = 2 (flush non-global) invalidates every slot whose global bit is clear and leaves global slots unchanged.
- R7: `flush_op` = 3 (flush address) invalidates every slot that a lookup of `flush_vpn` under `flush_asn` would hit, using the R1 rule, and leaves all other slots unchanged.
- R8: The `idx_*` outputs show the slot under `rp_slot`. With `idx_adv` high, the pointer advances by one in the same way as for an insert. An insert and `idx_adv` in the same cycle advance it by one only.
- R9: A flush and an insert in the same cycle behave as the flush followed by the insert. After flush-all plus insert, the new mapping is in slot 0 and `rp_slot` is 1. A new mapping survives a same-cycle flush-address that names it. `flush_op` = 0 issues no flush.
- R10: After reset every slot is invalid and `rp_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asn | input | ASN_W | Current address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | clog2(ENTRIES) | Slot that hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_rd_en | output | MODES | Per-mode read enables of the hit |
| lk_wr_en | output | MODES | Per-mode write enables of the hit |
| lk_fault_rd | output | 1 | Fault-on-read bit of the hit |
| lk_fault_wr | output | 1 | Fault-on-write bit of the hit |
| lk_global | output | 1 | Global bit of the hit |
| ins_en | input | 1 | Insert a mapping this cycle |
| ins_vpn | input | VPN_W | Tag of the new mapping |
| ins_asn | input | ASN_W | Owner address space number |
| ins_ppn | input | PPN_W | Physical page number |
| ins_rd_en | input | MODES | Per-mode read enables |
| ins_wr_en | input | MODES | Per-mode write enables |
| ins_fault_rd | input | 1 | Fault-on-read bit |
| ins_fault_wr | input | 1 | Fault-on-write bit |
| ins_global | input | 1 | Global bit |
| flush_op | input | 2 | 0 none, 1 all, 2 non-global, 3 address |
| flush_vpn | input | VPN_W | Page for flush-address |
| flush_asn | input | ASN_W | Address space number for flush-address |
| idx_adv | input | 1 | Step the replacement pointer |
| rp_slot | output | clog2(ENTRIES) | Replacement pointer |
| idx_valid | output | 1 | Valid bit of the slot at the pointer |
| idx_vpn | output | VPN_W | Tag of the slot at the pointer |
| idx_asn | output | ASN_W | Address space number of the slot at the pointer |
| idx_ppn | output | PPN_W | Physical page number of the slot at the pointer |
| idx_global | output | 1 | Global bit of the slot at the pointer |

## Verification
If a valid bit is corrupted or an invalidation misses a slot, the next lookup of that page shows it directly: the hit flag is wrong in the very cycle the page is presented. A tag or data field stored in the wrong place appears as a wrong slot number or physical page on a hit. A drifting replacement pointer shows at once on `rp_slot` and the index outputs. It also shows later, when an insert overwrites the wrong mapping and a lookup that should still hit misses. The bench therefore compares every lookup, the pointer and the index outputs against a reference model after each command. It fills the whole buffer so the pointer wraps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      FL_NONE   = 2'd0,
      FL_ALL    = 2'd1,
      FL_NONGLB = 2'd2,
      FL_ADDR   = 2'd3
   } flush_op_e;

endpackage

// File: rtl/tlb_replace_ptr.sv
module tlb_replace_ptr #(
   parameter int ENTRIES = 48,
   localparam int IW = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [IW-1:0] ptr
);

   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
   localparam logic [IW-1:0] ONE  = IW'(1);

   logic [IW-1:0] ptr_inc;

   generate
      if ((1 << IW) == ENTRIES) begin : g_pow2
         assign ptr_inc = ptr + ONE;
      end else begin : g_wrap
         assign ptr_inc = (ptr == LAST) ? '0 : ptr + ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= adv ? ONE : '0;
      else if (adv) ptr <= ptr_inc;
   end

   p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + ONE));

   p_clear_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !adv) |=> ptr == '0);

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int VPN_W   = 20,
   parameter int ASN_W   = 8,
   parameter int PPN_W   = 20,
   parameter int MODES   = 4,
   localparam int IW     = $clog2(ENTRIES),
   localparam int EW     = VPN_W + ASN_W + PPN_W + 2*MODES + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  flush_op_e          fl_op,
   input  logic [VPN_W-1:0]   fl_vpn,
   input  logic [ASN_W-1:0]   fl_asn,
   input  logic               ins_en,
   input  logic [IW-1:0]      ins_slot,
   input  logic [EW-1:0]      ins_data,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [ASN_W-1:0]   lk_asn,
   output logic [ENTRIES-1:0] lk_match,
   input  logic [IW-1:0]      rd_a_slot,
   output logic [EW-1:0]      rd_a_data,
   input  logic [IW-1:0]      rd_b_slot,
   output logic [EW-1:0]      rd_b_data,
   output logic               rd_b_valid
);

   localparam int O_ASN = VPN_W;
   localparam int O_G   = EW - 1;

   logic [ENTRIES-1:0] vld_q;
   logic [EW-1:0]      ent_q [ENTRIES];
   logic [ENTRIES-1:0] fl_match;
   logic [ENTRIES-1:0] glob_vec;
   logic [ENTRIES-1:0] kill;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         logic [VPN_W-1:0] tag;
         logic [ASN_W-1:0] own;
         assign tag         = ent_q[i][VPN_W-1:0];
         assign own         = ent_q[i][O_ASN +: ASN_W];
         assign glob_vec[i] = ent_q[i][O_G];
         assign lk_match[i] = vld_q[i] && (tag == lk_vpn) && (glob_vec[i] || own == lk_asn);
         assign fl_match[i] = vld_q[i] && (tag == fl_vpn) && (glob_vec[i] || own == fl_asn);

         always_comb begin
            unique case (fl_op)
               FL_ALL:    kill[i] = 1'b1;
               FL_NONGLB: kill[i] = !glob_vec[i];
               FL_ADDR:   kill[i] = fl_match[i];
               default:   kill[i] = 1'b0;
            endcase
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[i] <= 1'b0;
               ent_q[i] <= '0;
            end else begin
               if (kill[i])          vld_q[i] <= 1'b0;
               if (fl_op == FL_ALL)  ent_q[i] <= '0;
               if (ins_en && ins_slot == IW'(i)) begin
                  vld_q[i] <= 1'b1;
                  ent_q[i] <= ins_data;
               end
            end
         end
      end
   endgenerate

   assign rd_a_data  = ent_q[rd_a_slot];
   assign rd_b_data  = ent_q[rd_b_slot];
   assign rd_b_valid = vld_q[rd_b_slot];

   p_insert_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |=> vld_q[$past(ins_slot)] &&
                 ent_q[$past(ins_slot)][VPN_W-1:0] == $past(ins_data[VPN_W-1:0]));

   p_all_gone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == FL_ALL && !ins_en) |=> vld_q == '0);

   p_private_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == FL_NONGLB && !ins_en) |=> (vld_q & ~glob_vec) == '0);

   p_global_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == FL_NONGLB && !ins_en) |=> (vld_q & glob_vec) == $past(vld_q & glob_vec));

   p_addr_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == FL_ADDR && !ins_en) |=> (vld_q & $past(fl_match)) == '0);

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int ENTRIES = 48,
   localparam int IW = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] req,
   output logic               any,
   output logic [IW-1:0]      idx
);

   localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

   p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[idx] && ((req & ((ONE << idx) - ONE)) == '0));

endmodule

// File: rtl/asn_tagged_tlb.sv
module asn_tagged_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int VPN_W   = 20,
   parameter int ASN_W   = 8,
   parameter int PPN_W   = 20,
   parameter int MODES   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [VPN_W-1:0]            lk_vpn,
   input  logic [ASN_W-1:0]            lk_asn,
   output logic                        lk_hit,
   output logic [$clog2(ENTRIES)-1:0]  lk_slot,
   output logic [PPN_W-1:0]            lk_ppn,
   output logic [MODES-1:0]            lk_rd_en,
   output logic [MODES-1:0]            lk_wr_en,
   output logic                        lk_fault_rd,
   output logic                        lk_fault_wr,
   output logic                        lk_global,
   input  logic                        ins_en,
   input  logic [VPN_W-1:0]            ins_vpn,
   input  logic [ASN_W-1:0]            ins_asn,
   input  logic [PPN_W-1:0]            ins_ppn,
   input  logic [MODES-1:0]            ins_rd_en,
   input  logic [MODES-1:0]            ins_wr_en,
   input  logic                        ins_fault_rd,
   input  logic                        ins_fault_wr,
   input  logic                        ins_global,
   input  logic [1:0]                  flush_op,
   input  logic [VPN_W-1:0]            flush_vpn,
   input  logic [ASN_W-1:0]            flush_asn,
   input  logic                        idx_adv,
   output logic [$clog2(ENTRIES)-1:0]  rp_slot,
   output logic                        idx_valid,
   output logic [VPN_W-1:0]            idx_vpn,
   output logic [ASN_W-1:0]            idx_asn,
   output logic [PPN_W-1:0]            idx_ppn,
   output logic                        idx_global
);

   localparam int IW    = $clog2(ENTRIES);
   localparam int O_ASN = VPN_W;
   localparam int O_PPN = O_ASN + ASN_W;
   localparam int O_RD  = O_PPN + PPN_W;
   localparam int O_WR  = O_RD + MODES;
   localparam int O_FR  = O_WR + MODES;
   localparam int O_FW  = O_FR + 1;
   localparam int O_G   = O_FW + 1;
   localparam int EW    = O_G + 1;

   generate
      if (ENTRIES < 2)  begin : g_bad_entries $error("ENTRIES must be at least 2");  end
      if (VPN_W < 1)    begin : g_bad_vpn     $error("VPN_W must be positive");      end
      if (ASN_W < 1)    begin : g_bad_asn     $error("ASN_W must be positive");      end
      if (PPN_W < 1)    begin : g_bad_ppn     $error("PPN_W must be positive");      end
      if (MODES < 1)    begin : g_bad_modes   $error("MODES must be positive");      end
   endgenerate

   flush_op_e          op;
   logic [ENTRIES-1:0] match;
   logic [IW-1:0]      sel;
   logic               any;
   logic [IW-1:0]      ptr;
   logic [IW-1:0]      wr_slot;
   logic [EW-1:0]      ins_data;
   logic [EW-1:0]      hit_data;
   logic [EW-1:0]      idx_data;
   logic               idx_v;

   assign op       = flush_op_e'(flush_op);
   assign wr_slot  = (op == FL_ALL) ? '0 : ptr;
   assign ins_data = {ins_global, ins_fault_wr, ins_fault_rd, ins_wr_en, ins_rd_en,
                      ins_ppn, ins_asn, ins_vpn};

   tlb_replace_ptr #(.ENTRIES(ENTRIES)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (op == FL_ALL),
      .adv   (ins_en || idx_adv),
      .ptr   (ptr)
   );

   tlb_entry_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .MODES(MODES)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fl_op      (op),
      .fl_vpn     (flush_vpn),
      .fl_asn     (flush_asn),
      .ins_en     (ins_en),
      .ins_slot   (wr_slot),
      .ins_data   (ins_data),
      .lk_vpn     (lk_vpn),
      .lk_asn     (lk_asn),
      .lk_match   (match),
      .rd_a_slot  (sel),
      .rd_a_data  (hit_data),
      .rd_b_slot  (ptr),
      .rd_b_data  (idx_data),
      .rd_b_valid (idx_v)
   );

   tlb_first_hit #(.ENTRIES(ENTRIES)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (match),
      .any   (any),
      .idx   (sel)
   );

   assign lk_hit      = any;
   assign lk_slot     = any ? sel : '0;
   assign lk_ppn      = any ? hit_data[O_PPN +: PPN_W] : '0;
   assign lk_rd_en    = any ? hit_data[O_RD +: MODES]  : '0;
   assign lk_wr_en    = any ? hit_data[O_WR +: MODES]  : '0;
   assign lk_fault_rd = any && hit_data[O_FR];
   assign lk_fault_wr = any && hit_data[O_FW];
   assign lk_global   = any && hit_data[O_G];

   assign rp_slot    = ptr;
   assign idx_valid  = idx_v;
   assign idx_vpn    = idx_data[VPN_W-1:0];
   assign idx_asn    = idx_data[O_ASN +: ASN_W];
   assign idx_ppn    = idx_data[O_PPN +: PPN_W];
   assign idx_global = idx_data[O_G];

   p_reset_empty_r10: assert property (@(posedge clk)
      $rose(rst_n) |-> (rp_slot == '0) && !idx_valid && !lk_hit);

   p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppn == '0) && (lk_slot == '0) && !lk_global);

endmodule

// File: tb/test_asn_tagged_tlb.sv
`timescale 1ns/1ps
module test_asn_tagged_tlb;

   localparam int N  = 48;
   localparam int VW = 20;
   localparam int AW = 8;
   localparam int PW = 20;
   localparam int MW = 4;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asn = '0;
   logic          lk_hit;
   logic [IW-1:0] lk_slot;
   logic [PW-1:0] lk_ppn;
   logic [MW-1:0] lk_rd_en, lk_wr_en;
   logic          lk_fault_rd, lk_fault_wr, lk_global;
   logic          ins_en = 1'b0;
   logic [VW-1:0] ins_vpn = '0;
   logic [AW-1:0] ins_asn = '0;
   logic [PW-1:0] ins_ppn = '0;
   logic          ins_global = 1'b0;
   logic [1:0]    flush_op = 2'd0;
   logic [VW-1:0] flush_vpn = '0;
   logic [AW-1:0] flush_asn = '0;
   logic          idx_adv = 1'b0;
   logic [IW-1:0] rp_slot;
   logic          idx_valid, idx_global;
   logic [VW-1:0] idx_vpn;
   logic [AW-1:0] idx_asn;
   logic [PW-1:0] idx_ppn;

   asn_tagged_tlb #(.ENTRIES(N), .VPN_W(VW), .ASN_W(AW), .PPN_W(PW), .MODES(MW)) i_asn_tagged_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_ppn(lk_ppn),
      .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd),
      .lk_fault_wr(lk_fault_wr), .lk_global(lk_global),
      .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_ppn(ins_ppn),
      .ins_rd_en(ins_ppn[3:0]), .ins_wr_en(ins_ppn[7:4]), .ins_fault_rd(ins_ppn[8]),
      .ins_fault_wr(ins_ppn[9]), .ins_global(ins_global),
      .flush_op(flush_op), .flush_vpn(flush_vpn), .flush_asn(flush_asn), .idx_adv(idx_adv),
      .rp_slot(rp_slot), .idx_valid(idx_valid), .idx_vpn(idx_vpn), .idx_asn(idx_asn),
      .idx_ppn(idx_ppn), .idx_global(idx_global)
   );

   // reference model
   bit            m_v   [N];
   logic [VW-1:0] m_vpn [N];
   logic [AW-1:0] m_asn [N];
   logic [PW-1:0] m_ppn [N];
   bit            m_g   [N];
   int            m_ptr;

   typedef struct {
      bit            hit;
      int            slot;
      logic [PW-1:0] ppn;
      logic [9:0]    perm;
      bit            glob;
      int            ptr;
      bit            iv;
      logic [VW-1:0] ivpn;
      logic [PW-1:0] ippn;
      string         req;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   function automatic void chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endfunction

   function automatic int m_find(logic [VW-1:0] v, logic [AW-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asn[i] == a)) return i;
      return -1;
   endfunction

   function automatic void m_apply(bit ins, logic [VW-1:0] v, logic [AW-1:0] a,
                                   logic [PW-1:0] p, bit g, logic [1:0] op,
                                   logic [VW-1:0] fv, logic [AW-1:0] fa, bit adv);
      for (int i = 0; i < N; i++) begin
         if (op == 2'd1) begin
            m_v[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0; m_g[i] = 0;
         end else if (op == 2'd2) begin
            if (!m_g[i]) m_v[i] = 0;
         end else if (op == 2'd3) begin
            if (m_v[i] && m_vpn[i] == fv && (m_g[i] || m_asn[i] == fa)) m_v[i] = 0;
         end
      end
      if (op == 2'd1) m_ptr = 0;
      if (ins) begin
         m_v[m_ptr] = 1; m_vpn[m_ptr] = v; m_asn[m_ptr] = a; m_ppn[m_ptr] = p; m_g[m_ptr] = g;
      end
      if (ins || adv) m_ptr = (m_ptr + 1) % N;
   endfunction

   task automatic step(bit ins, logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p, bit g,
                       logic [1:0] op, logic [VW-1:0] fv, logic [AW-1:0] fa, bit adv);
      @(posedge clk); #1;
      ins_en = ins; ins_vpn = v; ins_asn = a; ins_ppn = p; ins_global = g;
      flush_op = op; flush_vpn = fv; flush_asn = fa; idx_adv = adv;
      @(posedge clk); #1;
      ins_en = 0; flush_op = 2'd0; idx_adv = 0;
      m_apply(ins, v, a, p, g, op, fv, fa, adv);
   endtask

   task automatic put(logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p, bit g);
      step(1, v, a, p, g, 2'd0, '0, '0, 0);
   endtask

   task automatic flush(logic [1:0] op, logic [VW-1:0] fv, logic [AW-1:0] fa);
      step(0, '0, '0, '0, 0, op, fv, fa, 0);
   endtask

   task automatic look(logic [VW-1:0] v, logic [AW-1:0] a, string req);
      exp_t e;
      int s;
      @(posedge clk); #1;
      lk_vpn = v; lk_asn = a;
      s = m_find(v, a);
      e.hit  = (s >= 0);
      e.slot = (s >= 0) ? s : 0;
      e.ppn  = (s >= 0) ? m_ppn[s] : '0;
      e.perm = (s >= 0) ? m_ppn[s][9:0] : '0;
      e.glob = (s >= 0) ? m_g[s] : 0;
      e.ptr  = m_ptr;
      e.iv   = m_v[m_ptr];
      e.ivpn = m_vpn[m_ptr];
      e.ippn = m_ppn[m_ptr];
      e.req  = req;
      q.push_back(e);
      @(negedge clk);
   endtask

   // monitor: compares design outputs against queued expectations at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(lk_hit == e.hit, e.req, "lk_hit", lk_hit, e.hit);
         chk(lk_slot == IW'(e.slot), e.req, "lk_slot", lk_slot, e.slot);
         chk(lk_ppn == e.ppn, e.req, "lk_ppn", lk_ppn, e.ppn);
         chk({lk_fault_wr, lk_fault_rd, lk_wr_en, lk_rd_en} == e.perm, e.req, "perm",
             {lk_fault_wr, lk_fault_rd, lk_wr_en, lk_rd_en}, e.perm);
         chk(lk_global == e.glob, e.req, "lk_global", lk_global, e.glob);
         chk(rp_slot == IW'(e.ptr), e.req, "rp_slot", rp_slot, e.ptr);
         chk(idx_valid == e.iv, e.req, "idx_valid", idx_valid, e.iv);
         if (e.iv) begin
            chk(idx_vpn == e.ivpn, e.req, "idx_vpn", idx_vpn, e.ivpn);
            chk(idx_ppn == e.ippn, e.req, "idx_ppn", idx_ppn, e.ippn);
         end
      end
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0; m_g[i] = 0;
      end
      m_ptr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: empty after reset
      look(20'h00005, 8'd0, "R10");

      // R1, R3: basic fills and ASN matching
      put(20'h00100, 8'd1, 20'h000A1, 0);
      put(20'h00200, 8'd2, 20'h001B2, 1);
      put(20'h00300, 8'd1, 20'h002C3, 0);
      look(20'h00100, 8'd1, "R3");
      look(20'h00100, 8'd2, "R1");
      look(20'h00200, 8'd7, "R1");
      look(20'h00300, 8'd1, "R3");
      look(20'h00301, 8'd1, "R1");

      // R2: duplicates, lowest slot wins
      put(20'h00100, 8'd1, 20'h003D4, 0);
      look(20'h00100, 8'd1, "R2");
      put(20'h00100, 8'd5, 20'h003E5, 0);
      look(20'h00100, 8'd5, "R2");

      // R7: flush one address under one ASN
      flush(2'd3, 20'h00100, 8'd1);
      look(20'h00100, 8'd1, "R7");
      look(20'h00100, 8'd5, "R7");
      look(20'h00300, 8'd1, "R7");

      // R6: flush non-global
      flush(2'd2, '0, '0);
      look(20'h00200, 8'd3, "R6");
      look(20'h00300, 8'd1, "R6");
      look(20'h00100, 8'd5, "R6");

      // R8: pointer step without insert
      step(0, '0, '0, '0, 0, 2'd0, '0, '0, 1);
      look(20'h00200, 8'd3, "R8");

      // R7: global mapping removed by flush-address under any ASN
      flush(2'd3, 20'h00200, 8'd9);
      look(20'h00200, 8'd9, "R7");

      // R4, R3: fill the whole buffer so the pointer wraps
      for (int k = 0; k < N; k++) begin
         put(VW'(32'h01000 + k), 8'd3, PW'(32'h04000 + k), 0);
         if (k == N - 7 || k == N - 6) look(20'h01000, 8'd3, "R4");
      end
      look(20'h01000, 8'd3, "R4");
      look(20'h01001, 8'd3, "R8");
      put(VW'(32'h01000 + N), 8'd3, 20'h05555, 0);
      look(20'h01000, 8'd3, "R3");
      look(VW'(32'h01000 + N), 8'd3, "R3");

      // R8: insert together with idx_adv advances once; idx outputs follow
      step(1, 20'h06000, 8'd3, 20'h06006, 0, 2'd0, '0, '0, 1);
      look(20'h06000, 8'd3, "R8");
      step(0, '0, '0, '0, 0, 2'd0, '0, '0, 1);
      look(20'h01002, 8'd3, "R8");

      // R9: flush-address and insert of the same page in one cycle
      put(20'h05000, 8'd3, 20'h00111, 0);
      step(1, 20'h05000, 8'd3, 20'h00222, 0, 2'd3, 20'h05000, 8'd3, 0);
      look(20'h05000, 8'd3, "R9");

      // R9, R5: flush-all with insert in the same cycle
      step(1, 20'h07000, 8'd4, 20'h00333, 0, 2'd1, '0, '0, 0);
      look(20'h07000, 8'd4, "R9");
      look(20'h01003, 8'd3, "R5");

      // R5: plain flush-all
      put(20'h08000, 8'd2, 20'h00444, 1);
      flush(2'd1, '0, '0);
      look(20'h08000, 8'd2, "R5");
      look(20'h07000, 8'd4, "R5");

      repeat (3) @(posedge clk);
      chk(q.size() == 0, "R1", "pending", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule